// File: doc/BRIEF.md
# Hashed requester-to-stream table writer

This block fills a 256-slot translation table. Each slot is a 32-bit word that pairs a 16-bit bus/device/function requester ID with a compact stream ID. A command port takes two kinds of command. A wipe command zeroes every slot. An insert command places one requester ID and its stream ID into the table. The home slot of a requester ID is a CRC-8 of its two bytes. When the home slot is occupied, the block steps forward through the slots until it finds an empty one. Each occupied slot it passes with an empty link field is threaded to the next slot probed, so that a lookup engine elsewhere can follow the chain.

The first insert after a wipe fixes the base stream ID. Every slot stores its stream ID as an offset from that base. The table lives in a single-port RAM outside the block. Reads return data one cycle after the request. The block takes one command at a time through a valid/ready handshake. It pulses `done` when a command finishes. When a probe comes back to the home slot without finding an empty slot, it pulses `full_err` together with `done`.

Top module: `sidtab_writer`

## Requirements
- R1: After reset, `busy`, `done`, `full_err` and `mem_en` are 0 and `cmd_ready` is 1.
- R2: A wipe command writes 0 to all 256 slots, one slot per cycle, then pulses `done` for exactly one cycle.
- R3: The home slot is a CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR, taken over the high byte of the requester ID and then the low byte. For example, ID 0x0001 maps to slot 0x07 and ID 0x0100 maps to slot 0x15.
- R4: A new entry holds the requester ID in bits 31:16, the relative stream ID in bits 15:8 and a link of 0 in bits 7:0.
- R5: The first insert after a wipe (or after reset) sets the base to its stream ID. Every stored stream ID is the low 8 bits of (stream ID − base).
- R6: When a probed slot is nonzero, the next slot probed is (slot + 1) mod 256. Slot 255 is followed by slot 0.
- R7: When a probed occupied slot has a link of 0, its link is rewritten to the index of the next slot to be probed, and its other fields are kept. A nonzero link is left unchanged.
- R8: If the next slot to probe would be the home slot, the insert stops with no new entry and no further link write, and `full_err` pulses in the same cycle as `done`.
- R9: `cmd_ready` is 1 only while the block is idle. A command offered while `busy` is 1 is not taken and has no effect on the table or on `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_clear | input | 1 | 1 = wipe command, 0 = insert command |
| cmd_bdf | input | 16 | Requester ID to insert |
| cmd_sid | input | SID_W | Absolute stream ID to insert |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| full_err | output | 1 | One-cycle pulse, with done, when an insert found no free slot |
| mem_en | output | 1 | Table RAM access request |
| mem_we | output | 1 | 1 = write, 0 = read (valid with mem_en) |
| mem_addr | output | 8 | Table slot index |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench targets the following corner cases:
- Colliding requester IDs stacked on one home slot. A design that overwrote links would break the chain, and one that skipped the link write would leave the chain cut.
- A probe that wraps from slot 255 to slot 0.
- A completely full table. A design that never noticed the wrap back to the home slot would hang or overwrite a slot, and the watchdog or the table compare shows it.
- The byte order of the hash, with known slots for 0x0001 and 0x0100. A little-endian hash swaps those two slots.
- Base capture across a wipe.
- Commands offered during a wipe, which must neither be taken nor produce a second `done`.

// File: rtl/sidtab_pkg.sv
package sidtab_pkg;

    localparam int BDF_W  = 16;
    localparam int REL_W  = 8;
    localparam int IDX_W  = 8;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int WORD_W = BDF_W + REL_W + IDX_W;

    typedef logic [IDX_W-1:0] slot_idx_t;

    typedef struct packed {
        logic [BDF_W-1:0] bdf;
        logic [REL_W-1:0] rel;
        logic [IDX_W-1:0] link;
    } slot_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WIPE,
        ST_FETCH,
        ST_EXAM
    } ctl_state_t;

    // MSB-first CRC over the whole ID: high byte then low byte, init 0.
    function automatic slot_idx_t crc_bdf(input logic [BDF_W-1:0] v,
                                          input slot_idx_t poly);
        slot_idx_t c;
        logic      fb;
        c = '0;
        for (int i = BDF_W - 1; i >= 0; i--) begin
            fb = c[IDX_W-1] ^ v[i];
            c  = {c[IDX_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/sidtab_hash.sv
module sidtab_hash
    import sidtab_pkg::*;
#(
    parameter slot_idx_t POLY = 8'h07
) (
    input  logic [BDF_W-1:0] bdf,
    output slot_idx_t        home
);
    assign home = crc_bdf(bdf, POLY);
endmodule

// File: rtl/sidtab_base.sv
module sidtab_base
    import sidtab_pkg::*;
#(
    parameter int SID_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe_go,
    input  logic             ins_go,
    input  logic [SID_W-1:0] sid,
    output logic [REL_W-1:0] rel
);
    logic             have_base;
    logic [SID_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_base <= 1'b0;
            base_q    <= '0;
            rel       <= '0;
        end else if (wipe_go) begin
            have_base <= 1'b0;
        end else if (ins_go) begin
            if (!have_base) begin
                base_q    <= sid;
                have_base <= 1'b1;
                rel       <= '0;
            end else begin
                rel <= REL_W'(sid - base_q);
            end
        end
    end

    // R5: the capture insert always stores offset zero
    p_first_offset_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (ins_go && !wipe_go && !have_base) |=> (rel == '0 && have_base));
endmodule

// File: rtl/sidtab_ctrl.sv
module sidtab_ctrl
    import sidtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_clear,
    input  logic [BDF_W-1:0]  cmd_bdf,
    input  slot_idx_t         home,
    input  logic [REL_W-1:0]  rel_sid,
    output logic              wipe_go,
    output logic              ins_go,
    output logic              busy,
    output logic              done,
    output logic              full_err,
    output logic              mem_en,
    output logic              mem_we,
    output slot_idx_t         mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    ctl_state_t       state;
    slot_idx_t        slot, start_q, nxt;
    logic [BDF_W-1:0] bdf_q;
    slot_word_t       rd_w, new_w, link_w;
    logic             accept, empty, wrap, need_link;

    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign wipe_go   = accept && cmd_clear;
    assign ins_go    = accept && !cmd_clear;

    assign nxt       = slot + 1'b1;
    assign rd_w      = slot_word_t'(mem_rdata);
    assign empty     = (mem_rdata == '0);
    assign wrap      = (nxt == start_q);
    assign need_link = (rd_w.link == '0);
    assign new_w     = '{bdf: bdf_q, rel: rel_sid, link: '0};
    assign link_w    = '{bdf: rd_w.bdf, rel: rd_w.rel, link: nxt};
    assign mem_addr  = slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            slot     <= '0;
            start_q  <= '0;
            bdf_q    <= '0;
            done     <= 1'b0;
            full_err <= 1'b0;
        end else begin
            done     <= 1'b0;
            full_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (wipe_go) begin
                        state <= ST_WIPE;
                        slot  <= '0;
                    end else if (ins_go) begin
                        state   <= ST_FETCH;
                        slot    <= home;
                        start_q <= home;
                        bdf_q   <= cmd_bdf;
                    end
                end
                ST_WIPE: begin
                    slot <= nxt;
                    if (slot == slot_idx_t'(DEPTH - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_FETCH: state <= ST_EXAM;
                ST_EXAM: begin
                    if (empty) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (wrap) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        full_err <= 1'b1;
                    end else begin
                        slot  <= nxt;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_WIPE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_FETCH: mem_en = 1'b1;
            ST_EXAM: begin
                if (empty) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = new_w;
                end else if (!wrap && need_link) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = link_w;
                end
            end
            default: ;
        endcase
    end

    // R9: a taken command makes the block busy and closes the port
    p_one_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));
    // R2: wipe cycles write zeros only
    p_wipe_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WIPE) |-> (mem_en && mem_we && mem_wdata == '0));
    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: consecutive probes step the address by one
    p_probe_step_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && $past(state) == ST_EXAM) |->
        (mem_addr == slot_idx_t'($past(mem_addr) + 1'b1)));
    // R7: a link write keeps the ID and offset read from the slot
    p_link_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXAM && mem_we && mem_rdata != '0) |->
        (mem_wdata[WORD_W-1:IDX_W] == mem_rdata[WORD_W-1:IDX_W] &&
         mem_rdata[IDX_W-1:0] == '0));
    // R4: a new entry ends its chain
    p_new_tail_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXAM && mem_we && mem_rdata == '0) |->
        (mem_wdata[IDX_W-1:0] == '0));
    // R8: the error only accompanies completion
    p_err_done_r8: assert property (@(posedge clk) disable iff (rst)
        full_err |-> done);
endmodule

// File: rtl/sidtab_writer.sv
module sidtab_writer
    import sidtab_pkg::*;
#(
    parameter slot_idx_t POLY  = 8'h07,
    parameter int        SID_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_clear,
    input  logic [15:0]       cmd_bdf,
    input  logic [SID_W-1:0]  cmd_sid,
    output logic              busy,
    output logic              done,
    output logic              full_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [7:0]        mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    slot_idx_t        home;
    logic [REL_W-1:0] rel_sid;
    logic             wipe_go, ins_go;

    sidtab_hash #(.POLY(POLY)) hash_i (
        .bdf  (cmd_bdf),
        .home (home)
    );

    sidtab_base #(.SID_W(SID_W)) base_i (
        .clk     (clk),
        .rst     (rst),
        .wipe_go (wipe_go),
        .ins_go  (ins_go),
        .sid     (cmd_sid),
        .rel     (rel_sid)
    );

    sidtab_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_clear (cmd_clear),
        .cmd_bdf   (cmd_bdf),
        .home      (home),
        .rel_sid   (rel_sid),
        .wipe_go   (wipe_go),
        .ins_go    (ins_go),
        .busy      (busy),
        .done      (done),
        .full_err  (full_err),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: tb/sidtab_writer_tb_top.sv
`timescale 1ns/1ps
module sidtab_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_clear = 1'b0;
    logic [15:0] cmd_bdf = '0;
    logic [15:0] cmd_sid = '0;
    logic        cmd_ready, busy, done, full_err;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sidtab_writer dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_clear(cmd_clear), .cmd_bdf(cmd_bdf), .cmd_sid(cmd_sid),
        .busy(busy), .done(done), .full_err(full_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // table RAM, one-cycle read latency; junk-filled during reset
    logic [31:0] ram [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= 32'hA5A5_0000 | i;
        end else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    // reference model
    logic [31:0] model [256];
    bit          m_have = 1'b0;
    logic [15:0] m_base = '0;

    function automatic logic [7:0] ref_hash(input logic [15:0] id);
        logic [7:0] c = 8'h00;
        logic [7:0] b;
        for (int k = 1; k >= 0; k--) begin
            b = id[8*k +: 8];
            c = c ^ b;
            for (int j = 0; j < 8; j++)
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic bit model_insert(input logic [15:0] id, input logic [15:0] sid);
        logic [7:0] h, s, n, rel;
        if (!m_have) begin m_base = sid; m_have = 1'b1; end
        rel = 8'(sid - m_base);
        h = ref_hash(id);
        s = h;
        forever begin
            if (model[s] == 32'h0) begin
                model[s] = {id, rel, 8'h00};
                return 1'b0;
            end
            n = s + 8'd1;
            if (n == h) return 1'b1;
            if (model[s][7:0] == 8'h00) model[s][7:0] = n;
            s = n;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { bit err; string tag; } exp_t;
    exp_t exp_q [$];

    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                int   bad;
                e = exp_q.pop_front();
                chk(full_err == e.err, {"R8 full_err ", e.tag}, 32'(full_err), 32'(e.err));
                bad = 0;
                for (int i = 0; i < 256; i++) if (ram[i] !== model[i]) bad++;
                chk(bad == 0, {"table compare ", e.tag}, bad, 0);
            end
        end
    end

    task automatic issue(input bit clr, input logic [15:0] id, input logic [15:0] sid,
                         input string tag);
        exp_t e;
        if (clr) begin
            for (int i = 0; i < 256; i++) model[i] = 32'h0;
            m_have = 1'b0;
            e.err = 1'b0;
        end else begin
            e.err = model_insert(id, sid);
        end
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_clear = clr; cmd_bdf = id; cmd_sid = sid;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    function automatic logic [15:0] find_id(input logic [7:0] h, input int nth);
        int seen = 0;
        for (int v = 1; v < 65536; v++) begin
            if (ref_hash(16'(v)) == h) begin
                if (seen == nth) return 16'(v);
                seen++;
            end
        end
        return 16'h0;
    endfunction

    initial begin
        logic [15:0] a, b, c, d, e2;
        for (int i = 0; i < 256; i++) model[i] = 32'hA5A5_0000 | i;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && full_err == 0 && mem_en == 0,
            "R1 idle outputs", {busy, done, full_err, mem_en}, 0);
        chk(cmd_ready == 1, "R1 ready", 32'(cmd_ready), 1);

        issue(1'b1, 0, 0, "R2 wipe");

        // R3 hash byte order, R4 layout, R5 base
        issue(1'b0, 16'h0001, 16'h0040, "R3 id 0001");
        chk(ram[8'h07] == {16'h0001, 8'h00, 8'h00}, "R3 R4 slot 07", ram[8'h07], 32'h0001_0000);
        issue(1'b0, 16'h0100, 16'h0045, "R3 id 0100");
        chk(ram[8'h15] == {16'h0100, 8'h05, 8'h00}, "R3 R5 slot 15", ram[8'h15], 32'h0100_0500);

        // R5 base re-captured after wipe
        issue(1'b1, 0, 0, "R2 wipe 2");
        issue(1'b0, 16'h0100, 16'h0045, "R5 recapture");
        chk(ram[8'h15] == {16'h0100, 8'h00, 8'h00}, "R5 offset zero", ram[8'h15], 32'h0100_0000);

        // R6 R7 collision chain on slot 0
        a = find_id(8'h00, 0); b = find_id(8'h00, 1); c = find_id(8'h00, 2);
        issue(1'b0, a, 16'h0046, "R6 chain a");
        issue(1'b0, b, 16'h0047, "R6 chain b");
        chk(ram[0][7:0] == 8'h01, "R7 link 0->1", ram[0][7:0], 1);
        chk(ram[1] == {b, 8'h02, 8'h00}, "R6 b in slot 1", ram[1], {b, 16'h0200});
        issue(1'b0, c, 16'h0048, "R6 chain c");
        chk(ram[0] == {a, 8'h01, 8'h01}, "R7 link kept", ram[0], {a, 16'h0101});
        chk(ram[1][7:0] == 8'h02, "R7 link 1->2", ram[1][7:0], 2);
        chk(ram[2] == {c, 8'h03, 8'h00}, "R4 c in slot 2", ram[2], {c, 16'h0300});

        // R6 wrap 255 -> 0
        issue(1'b1, 0, 0, "R2 wipe 3");
        d = find_id(8'hFF, 0); e2 = find_id(8'hFF, 1);
        issue(1'b0, d, 16'h0010, "R6 wrap d");
        issue(1'b0, e2, 16'h0013, "R6 wrap e");
        chk(ram[0] == {e2, 8'h03, 8'h00}, "R6 wrapped to 0", ram[0], {e2, 16'h0300});

        // R9 commands during a wipe are ignored
        begin
            exp_t w;
            for (int i = 0; i < 256; i++) model[i] = 32'h0;
            m_have = 1'b0;
            w.err = 1'b0; w.tag = "R9 wipe busy";
            exp_q.push_back(w);
            @(negedge clk);
            cmd_valid = 1'b1; cmd_clear = 1'b1;
            @(negedge clk);
            cmd_clear = 1'b0; cmd_bdf = 16'h0042; cmd_sid = 16'h0099;
            for (int i = 0; i < 10; i++) begin
                chk(cmd_ready == 0, "R9 not ready while busy", 32'(cmd_ready), 0);
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(ram[ref_hash(16'h0042)] == 0, "R9 ignored insert", ram[ref_hash(16'h0042)], 0);
        end

        // R8 full table
        for (int k = 0; k < 256; k++)
            issue(1'b0, 16'((k + 1) & 8'hFF), 16'(16'h0100 + k), "R8 fill");
        issue(1'b0, 16'h1234, 16'h0300, "R8 overflow");
        begin
            int hits = 0;
            for (int i = 0; i < 256; i++) if (ram[i][31:16] == 16'h1234) hits++;
            chk(hits == 0, "R8 no entry stored", hits, 0);
        end

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule